// File: doc/BRIEF.md
# Single-Channel Bus-Hold DMA Engine

The engine moves a block of words without help from the processor. It has three sides. On the device side, a request line starts a block, an acknowledge line answers it, and two strobes move data. On the processor side, the engine asks for the shared bus with `hold_o` and waits for the grant on `hlda_i`. On the memory side, it acts as bus master: it drives the address, the write data and the read/write strobes, and only while the grant is present.

Software sets up a block through a small write-only configuration port:

| `cfg_sel_i` | Register |
|---|---|
| 0 | Pointer A |
| 1 | Pointer B |
| 2 | Word count |
| 3 | Control: bits [1:0] select the mode, bit 2 starts the block |

There are three modes:

- **Memory to device (mode 0).** Each granted cycle reads one memory word at pointer A and presents it to the device in the same cycle.
- **Device to memory (mode 1).** Each granted cycle takes one device word and writes it at pointer A.
- **Memory to memory (mode 2).** Each word takes two granted cycles: a read at pointer A into an internal holding register, then a write of that register at pointer B.

Both pointers increment by one after each word they address. The count decrements once per word. When the last word is done, the engine drops HOLD and DACK and raises a done flag. If the grant is withdrawn during a block, the engine releases the bus at once and resumes later from the same pointers and count.

Top module: `dma_hold_engine`

## Requirements
- R1: After reset, `hold_o`, `dack_o`, `mem_oe_o`, `mem_rd_o`, `mem_wr_o`, `dev_rd_o`, `dev_wr_o` and `done_o` are all low.
- R2: A start in mode 0 or 1 raises `hold_o` only after `dreq_i` has been seen high. A start in mode 2 raises `hold_o` on the cycle after the start write, without any device request.
- R3: While `hlda_i` is low, `mem_oe_o` and every strobe are low and `mem_addr_o` and both write-data outputs are zero. `mem_rd_o` and `mem_wr_o` are never high together.
- R4: `dack_o` is high only inside a HOLD period in which `hlda_i` has already been seen high, and only in modes 0 and 1. `hold_o` and `dack_o` fall together, on the same edge that raises `done_o`.
- R5: In mode 0, each granted word cycle asserts `mem_rd_o` and `dev_wr_o` together. Memory word `A+k` reaches the device as the k-th word.
- R6: In mode 1, each granted word cycle asserts `dev_rd_o` and `mem_wr_o` together. The k-th device word is written at address `A+k`.
- R7: In mode 2, word k is read from `A+k` and then written to `B+k`. Memory outside `B..B+N-1` is not written.
- R8: Exactly N words move for a count of N. `done_o` rises at the end of the block and clears on the next accepted start whose count is nonzero.
- R9: A low `hlda_i` in the middle of a block moves no word and loses no address or count. The block completes correctly once the grant returns.
- R10: A start with a count of zero sets `done_o` and never raises `hold_o`.
- R11: Configuration writes and start writes made while a block is pending or running have no effect on the block in progress.
- R12: A start write with mode value 3 is ignored: `hold_o` stays low even when `dreq_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Register select: 0 pointer A, 1 pointer B, 2 count, 3 control |
| cfg_wdata_i | input | CFG_W | Configuration write data |
| dreq_i | input | 1 | Device request |
| dack_o | output | 1 | Device acknowledge |
| dev_rd_o | output | 1 | Strobe that takes a word from the device |
| dev_rdata_i | input | DW | Word from the device |
| dev_wr_o | output | 1 | Strobe that hands a word to the device |
| dev_wdata_o | output | DW | Word to the device |
| hold_o | output | 1 | Bus request to the processor |
| hlda_i | input | 1 | Bus grant from the processor |
| mem_oe_o | output | 1 | Memory bus output enable |
| mem_addr_o | output | AW | Memory address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | DW | Memory read data, valid in the strobe cycle |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | DW | Memory write data |
| done_o | output | 1 | Block complete flag |

## Verification
Directed blocks exercise each mode with a count of one, a zero count, the reserved mode, and configuration writes made while busy. A long run with frequent grant drops separates a correct pause from one that skips words, repeats words or lets strobes leak while the bus is not granted. Seeded random blocks vary the mode, the length, both pointers and how often the grant drops. In every block, delivered data and untouched neighbour words are compared against bench-computed patterns, which tells apart off-by-one counts, a swapped source and destination, and pointer slips. A continuous monitor flags any bus drive without a grant, any acknowledge before the grant or during memory-to-memory, and any request raised before the device asked.

// File: rtl/dma_hold_pkg.sv
package dma_hold_pkg;

  typedef enum logic [1:0] {
    XM_MEM2DEV = 2'd0,
    XM_DEV2MEM = 2'd1,
    XM_MEM2MEM = 2'd2,
    XM_RSVD    = 2'd3
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_REQ   = 3'd2,
    ST_MOVE  = 3'd3,
    ST_WRB   = 3'd4
  } seq_state_e;

  localparam logic [1:0] SEL_PTR_A = 2'd0;
  localparam logic [1:0] SEL_PTR_B = 2'd1;
  localparam logic [1:0] SEL_CNT   = 2'd2;
  localparam logic [1:0] SEL_CTRL  = 2'd3;
  localparam int unsigned CTRL_GO_BIT = 2;

endpackage

// File: rtl/dma_hold_cfg.sv
module dma_hold_cfg
  import dma_hold_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned CW    = 16,
  parameter int unsigned CFG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             idle_i,
  input  logic             step_a_i,
  input  logic             step_b_i,
  input  logic             step_cnt_i,
  output logic [AW-1:0]    ptr_a_o,
  output logic [AW-1:0]    ptr_b_o,
  output xfer_mode_e       mode_o,
  output logic             go_o,
  output xfer_mode_e       go_mode_o,
  output logic             cnt_zero_o,
  output logic             cnt_last_o
);

  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [AW-1:0] ptr_a_q, ptr_b_q;
  logic [CW-1:0] cnt_q;
  xfer_mode_e    mode_q;
  logic          wr_ok;

  // writes land only while no block is pending or running
  assign wr_ok     = cfg_we_i & idle_i;
  assign go_mode_o = xfer_mode_e'(cfg_wdata_i[1:0]);
  assign go_o      = wr_ok & (cfg_sel_i == SEL_CTRL) & cfg_wdata_i[CTRL_GO_BIT]
                   & (go_mode_o != XM_RSVD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_a_q <= '0;
      ptr_b_q <= '0;
      cnt_q   <= '0;
      mode_q  <= XM_MEM2DEV;
    end else begin
      if (wr_ok && cfg_sel_i == SEL_PTR_A) ptr_a_q <= cfg_wdata_i[AW-1:0];
      else if (step_a_i)                   ptr_a_q <= ptr_a_q + AW'(1);
      if (wr_ok && cfg_sel_i == SEL_PTR_B) ptr_b_q <= cfg_wdata_i[AW-1:0];
      else if (step_b_i)                   ptr_b_q <= ptr_b_q + AW'(1);
      if (wr_ok && cfg_sel_i == SEL_CNT)   cnt_q   <= cfg_wdata_i[CW-1:0];
      else if (step_cnt_i)                 cnt_q   <= cnt_q - CNT_ONE;
      if (go_o)                            mode_q  <= go_mode_o;
    end
  end

  assign ptr_a_o    = ptr_a_q;
  assign ptr_b_o    = ptr_b_q;
  assign mode_o     = mode_q;
  assign cnt_zero_o = (cnt_q == '0);
  assign cnt_last_o = (cnt_q == CNT_ONE);

  // R8: a word is never counted from an empty counter
  a_r8_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_cnt_i |-> (cnt_q != '0));

  // R11, R9: while busy, pointer A moves only on a granted word
  a_r11_ptr_a_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_i && !step_a_i) |=> $stable(ptr_a_q));

  a_r11_cnt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_i && !step_cnt_i) |=> $stable(cnt_q));

  a_r11_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> $stable(mode_q));

endmodule

// File: rtl/dma_hold_seq.sv
module dma_hold_seq
  import dma_hold_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  xfer_mode_e go_mode_i,
  input  xfer_mode_e mode_i,
  input  logic       cnt_zero_i,
  input  logic       cnt_last_i,
  input  logic       dreq_i,
  input  logic       hlda_i,
  output logic       idle_o,
  output logic       hold_o,
  output logic       dack_o,
  output logic       rd_phase_o,
  output logic       wr_phase_o,
  output logic       step_a_o,
  output logic       step_b_o,
  output logic       step_cnt_o,
  output logic       done_o
);

  seq_state_e st_q, st_d;
  logic       done_q, done_d;
  logic       io_mode;

  assign io_mode    = (mode_i != XM_MEM2MEM);
  assign rd_phase_o = (st_q == ST_MOVE);
  assign wr_phase_o = (st_q == ST_WRB);

  assign step_a_o   = rd_phase_o & hlda_i;
  assign step_b_o   = wr_phase_o & hlda_i;
  assign step_cnt_o = hlda_i & ((rd_phase_o & io_mode) | wr_phase_o);

  always_comb begin
    st_d   = st_q;
    done_d = done_q;
    unique case (st_q)
      ST_IDLE: begin
        if (go_i) begin
          if (cnt_zero_i) begin
            done_d = 1'b1;
          end else begin
            done_d = 1'b0;
            st_d   = (go_mode_i == XM_MEM2MEM) ? ST_REQ : ST_ARMED;
          end
        end
      end
      ST_ARMED: if (dreq_i) st_d = ST_REQ;
      ST_REQ:   if (hlda_i) st_d = ST_MOVE;
      ST_MOVE: begin
        if (hlda_i) begin
          if (!io_mode) begin
            st_d = ST_WRB;
          end else if (cnt_last_i) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
      end
      ST_WRB: begin
        if (hlda_i) begin
          if (cnt_last_i) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            st_d = ST_MOVE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  assign idle_o = (st_q == ST_IDLE);
  assign hold_o = (st_q == ST_REQ) | (st_q == ST_MOVE) | (st_q == ST_WRB);
  assign dack_o = (st_q == ST_MOVE) & io_mode;
  assign done_o = done_q;

  // R4: acknowledge lies inside a hold period
  a_r4_dack_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> hold_o);

  // R4: acknowledge rises only after a grant has been seen
  a_r4_dack_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dack_o) |-> $past(hlda_i));

  // R4: hold and acknowledge drop together and done is raised
  a_r4_release_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> (!dack_o && done_o));

  // R10: zero-length start never requests the bus
  a_r10_zero_no_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && cnt_zero_i) |=> (!hold_o && done_o));

  // R9: no word advances without a grant
  a_r9_pause_no_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hlda_i |-> !(step_a_o || step_b_o || step_cnt_o));

  // R2: device modes wait for a request before asking for the bus
  a_r2_req_before_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARMED && !dreq_i) |=> !hold_o);

endmodule

// File: rtl/dma_hold_bus.sv
module dma_hold_bus
  import dma_hold_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  xfer_mode_e    mode_i,
  input  logic          rd_phase_i,
  input  logic          wr_phase_i,
  input  logic          hlda_i,
  input  logic [AW-1:0] ptr_a_i,
  input  logic [AW-1:0] ptr_b_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] dev_rdata_i,
  output logic          mem_oe_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          dev_rd_o,
  output logic          dev_wr_o,
  output logic [DW-1:0] dev_wdata_o
);

  logic          live;
  logic          m2m;
  logic [DW-1:0] stash_q;

  assign live = hlda_i & (rd_phase_i | wr_phase_i);
  assign m2m  = (mode_i == XM_MEM2MEM);

  always_comb begin
    mem_oe_o    = live;
    mem_addr_o  = '0;
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    mem_wdata_o = '0;
    dev_rd_o    = 1'b0;
    dev_wr_o    = 1'b0;
    dev_wdata_o = '0;
    if (live) begin
      mem_addr_o = wr_phase_i ? ptr_b_i : ptr_a_i;
      if (wr_phase_i) begin
        mem_wr_o    = 1'b1;
        mem_wdata_o = stash_q;
      end else if (mode_i == XM_DEV2MEM) begin
        // device word passes straight onto the memory bus
        dev_rd_o    = 1'b1;
        mem_wr_o    = 1'b1;
        mem_wdata_o = dev_rdata_i;
      end else begin
        mem_rd_o = 1'b1;
        if (!m2m) begin
          dev_wr_o    = 1'b1;
          dev_wdata_o = mem_rdata_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      stash_q <= '0;
    else if (live && rd_phase_i && m2m) stash_q <= mem_rdata_i;
  end

  // R3: nothing is driven without a grant
  a_r3_oe_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hlda_i |-> (!mem_oe_o && !mem_rd_o && !mem_wr_o && !dev_rd_o && !dev_wr_o
                 && mem_addr_o == '0));

  a_r3_one_direction: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  // R7: memory-to-memory never strobes the device
  a_r7_no_device: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m2m |-> (!dev_rd_o && !dev_wr_o));

  // R7: the held word is kept until its write cycle
  a_r7_stash_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_phase_i && !hlda_i) |=> $stable(stash_q));

endmodule

// File: rtl/dma_hold_engine.sv
module dma_hold_engine
  import dma_hold_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned CW    = 16,
  parameter int unsigned CFG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             dreq_i,
  output logic             dack_o,
  output logic             dev_rd_o,
  input  logic [DW-1:0]    dev_rdata_i,
  output logic             dev_wr_o,
  output logic [DW-1:0]    dev_wdata_o,
  output logic             hold_o,
  input  logic             hlda_i,
  output logic             mem_oe_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_rd_o,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             mem_wr_o,
  output logic [DW-1:0]    mem_wdata_o,
  output logic             done_o
);

  logic          idle, go, cnt_zero, cnt_last;
  logic          rd_phase, wr_phase, step_a, step_b, step_cnt;
  logic [AW-1:0] ptr_a, ptr_b;
  xfer_mode_e    mode, go_mode;

  dma_hold_cfg #(.AW(AW), .CW(CW), .CFG_W(CFG_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_sel_i  (cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i),
    .idle_i     (idle),
    .step_a_i   (step_a),
    .step_b_i   (step_b),
    .step_cnt_i (step_cnt),
    .ptr_a_o    (ptr_a),
    .ptr_b_o    (ptr_b),
    .mode_o     (mode),
    .go_o       (go),
    .go_mode_o  (go_mode),
    .cnt_zero_o (cnt_zero),
    .cnt_last_o (cnt_last)
  );

  dma_hold_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go),
    .go_mode_i  (go_mode),
    .mode_i     (mode),
    .cnt_zero_i (cnt_zero),
    .cnt_last_i (cnt_last),
    .dreq_i     (dreq_i),
    .hlda_i     (hlda_i),
    .idle_o     (idle),
    .hold_o     (hold_o),
    .dack_o     (dack_o),
    .rd_phase_o (rd_phase),
    .wr_phase_o (wr_phase),
    .step_a_o   (step_a),
    .step_b_o   (step_b),
    .step_cnt_o (step_cnt),
    .done_o     (done_o)
  );

  dma_hold_bus #(.AW(AW), .DW(DW)) u_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .rd_phase_i (rd_phase),
    .wr_phase_i (wr_phase),
    .hlda_i     (hlda_i),
    .ptr_a_i    (ptr_a),
    .ptr_b_i    (ptr_b),
    .mem_rdata_i(mem_rdata_i),
    .dev_rdata_i(dev_rdata_i),
    .mem_oe_o   (mem_oe_o),
    .mem_addr_o (mem_addr_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .mem_wdata_o(mem_wdata_o),
    .dev_rd_o   (dev_rd_o),
    .dev_wr_o   (dev_wr_o),
    .dev_wdata_o(dev_wdata_o)
  );

endmodule

// File: tb/dma_hold_engine_bench.sv
`timescale 1ns/1ps
module dma_hold_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        dreq = 1'b0;
  logic        hlda = 1'b0;
  logic        dack, dev_rd, dev_wr, hold, mem_oe, mem_rd, mem_wr, done;
  logic [15:0] dev_rdata, dev_wdata, mem_addr, mem_rdata, mem_wdata;

  logic [15:0] mem [0:1023];
  logic [15:0] rx  [0:63];
  int          rx_n = 0;
  int          dev_idx = 0;
  logic [15:0] dev_base = '0;
  int          drop_pct = 0;
  logic        hold_seen = 1'b0;
  logic        granted = 1'b0;
  logic        in_m2m = 1'b0;
  int          v_r3 = 0, v_r4 = 0;
  int          n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:0]];
  assign dev_rdata = dev_base + 16'(dev_idx * 3);

  dma_hold_engine u_dma_hold_engine (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .dreq_i(dreq), .dack_o(dack), .dev_rd_o(dev_rd),
    .dev_rdata_i(dev_rdata), .dev_wr_o(dev_wr), .dev_wdata_o(dev_wdata),
    .hold_o(hold), .hlda_i(hlda), .mem_oe_o(mem_oe), .mem_addr_o(mem_addr),
    .mem_rd_o(mem_rd), .mem_rdata_i(mem_rdata), .mem_wr_o(mem_wr),
    .mem_wdata_o(mem_wdata), .done_o(done)
  );

  // memory and device models
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
    if (dev_rd) dev_idx <= dev_idx + 1;
    if (dev_wr) begin
      rx[rx_n[5:0]] <= dev_wdata;
      rx_n <= rx_n + 1;
    end
  end

  // processor model: grants one cycle after hold, drops the grant at random
  initial forever begin
    @(negedge clk);
    if (!hold) hlda <= 1'b0;
    else if (hold_seen) hlda <= (int'($urandom_range(99)) >= drop_pct);
    hold_seen <= hold;
  end

  // continuous protocol monitor
  initial forever begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (!hlda && (mem_oe || mem_rd || mem_wr || dev_rd || dev_wr || mem_addr != 0))
        v_r3++;
      if (mem_rd && mem_wr) v_r3++;
      if (dack && (!granted || !hold || in_m2m)) v_r4++;
      if (hold && hlda) granted = 1'b1;
      if (!hold) granted = 1'b0;
    end
  end

  function automatic logic [15:0] pat(input int i, input int salt);
    return 16'(i * 40503 + salt * 7 + 11);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_block(input int mode, input int pa, input int pb, input int cnt,
                           input int drop, input bit busy_wr, input int salt);
    int v3, v4, bad, waited, hold_early;
    drop_pct = drop;
    for (int i = 0; i < 1024; i++) mem[i] = pat(i, salt);
    dev_base = 16'(salt * 91);
    dev_idx = 0; rx_n = 0; bad = 0; hold_early = 0;
    in_m2m = (mode == 2);
    v3 = v_r3; v4 = v_r4;
    cfg_write(2'd0, 16'(pa));
    cfg_write(2'd1, 16'(pb));
    cfg_write(2'd2, 16'(cnt));
    cfg_write(2'd3, 16'(4 | mode));
    #1;
    chk("R8", "done cleared by start", int'(done), 0);
    if (mode == 2) chk("R2", "hold after m2m start", int'(hold), 1);
    if (busy_wr) begin
      cfg_write(2'd0, 16'h0300);
      cfg_write(2'd1, 16'h0100);
      cfg_write(2'd2, 16'd5);
      cfg_write(2'd3, 16'h0005);
    end
    if (mode != 2) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk); #1;
        if (hold) hold_early++;
      end
      chk("R2", "hold before dreq", hold_early, 0);
      dreq = 1'b1;
    end
    waited = 0;
    do begin
      @(negedge clk); #1;
      waited++;
    end while (!done && waited < 4000);
    chk("R8", "block completed", int'(done), 1);
    chk("R4", "hold/dack low at done", int'({hold, dack}), 0);
    dreq = 1'b0;
    @(negedge clk); #1;
    case (mode)
      0: begin
        chk("R5", "device word count", rx_n, cnt);
        for (int k = 0; k < cnt && k < 64; k++)
          if (rx[k] !== pat(pa + k, salt)) begin
            if (bad == 0) chk("R5", $sformatf("device word %0d", k), int'(rx[k]), int'(pat(pa + k, salt)));
            bad++;
          end
        if (bad == 0) chk("R5", "device data", 0, 0);
      end
      1: begin
        chk("R6", "device reads", dev_idx, cnt);
        for (int k = 0; k < cnt; k++)
          if (mem[pa + k] !== 16'(int'(dev_base) + k * 3)) begin
            if (bad == 0) chk("R6", $sformatf("mem word %0d", k), int'(mem[pa + k]), (int'(dev_base) + k * 3) & 16'hffff);
            bad++;
          end
        if (bad == 0) chk("R6", "memory data", 0, 0);
        chk("R8", "word after block untouched", int'(mem[pa + cnt]), int'(pat(pa + cnt, salt)));
      end
      default: begin
        for (int k = 0; k < cnt; k++)
          if (mem[pb + k] !== pat(pa + k, salt)) begin
            if (bad == 0) chk("R7", $sformatf("copy word %0d", k), int'(mem[pb + k]), int'(pat(pa + k, salt)));
            bad++;
          end
        if (bad == 0) chk("R7", "copied data", 0, 0);
        chk("R7", "word after dest untouched", int'(mem[pb + cnt]), int'(pat(pb + cnt, salt)));
        chk("R7", "word before dest untouched", int'(mem[pb - 1]), int'(pat(pb - 1, salt)));
        chk("R7", "no device strobes", rx_n + dev_idx, 0);
      end
    endcase
    chk("R3", "bus released without grant", v_r3 - v3, 0);
    chk("R4", "dack ordering", v_r4 - v4, 0);
    in_m2m = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R8 watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "outputs in reset",
        int'({hold, dack, mem_oe, mem_rd, mem_wr, dev_rd, dev_wr, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "outputs after reset",
        int'({hold, dack, mem_oe, mem_rd, mem_wr, dev_rd, dev_wr, done}), 0);

    // R10: zero count
    cfg_write(2'd2, 16'd0);
    cfg_write(2'd3, 16'h0004);
    #1;
    chk("R10", "done on zero count", int'(done), 1);
    repeat (3) @(negedge clk);
    #1;
    chk("R10", "no hold on zero count", int'(hold), 0);

    // R12: reserved mode is ignored
    cfg_write(2'd2, 16'd4);
    cfg_write(2'd3, 16'h0007);
    dreq = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    chk("R12", "hold with reserved mode", int'(hold), 0);
    chk("R12", "done unchanged", int'(done), 1);
    dreq = 1'b0;

    // directed: single words, each mode
    run_block(0, 10, 600, 1, 0, 1'b0, 1);
    run_block(1, 20, 600, 1, 0, 1'b0, 2);
    run_block(2, 30, 600, 1, 0, 1'b0, 3);
    // R9: heavy grant drops
    run_block(0, 40, 600, 30, 60, 1'b0, 4);
    run_block(1, 50, 600, 30, 60, 1'b0, 5);
    run_block(2, 60, 640, 30, 60, 1'b0, 6);
    // R11: writes while busy
    run_block(0, 70, 600, 12, 20, 1'b1, 7);
    run_block(2, 80, 700, 12, 20, 1'b1, 8);

    // seeded random blocks
    for (int r = 0; r < 14; r++)
      run_block(int'($urandom_range(2)), int'($urandom_range(0, 200)),
                512 + int'($urandom_range(1, 200)), int'($urandom_range(1, 40)),
                int'($urandom_range(0, 40)), bit'($urandom_range(1)), 20 + r);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule